// File: doc/BRIEF.md
# Smart-Card Answer-To-Reset Parser

This block follows the answer-to-reset byte sequence that a contact smart card sends after reset, without driving the line. Each byte arrives on `byte_data` together with a one-cycle `byte_valid` strobe from a character receiver elsewhere in the chip. The parser steps through the initial character, the format byte, the chained interface bytes, the historical bytes and an optional check byte. It then raises `done` and holds it.

The parser keeps a 16-bit mask of the protocol numbers the card lists and latches the work waiting integer from the proper interface byte. When the sequence ends it computes the work waiting time in elementary time units from that integer and the current rate adjustment code. The first 64 accepted bytes go into a buffer with a combinational read port. The check byte is consumed but not verified, and only direct convention is handled.

Top module: `atr_stream_parser`

## Requirements
- R1: After reset (rst_n low at a clock edge) `done`=0, `next_slot`=0, `proto_mask`=0x0001, `wi_value`=10, `wait_etu`=9600, and every buffer entry reads 0.
- R2: While the initial character is awaited, a byte of value 0x00 is dropped and `next_slot` does not move. Any other value is stored, and the parser then expects the format byte.
- R3: In the format byte, bits 3:0 give the number of historical bytes and bits 7:4 give the presence mask for the interface bytes. The interface bytes follow in the order: A (bit 4), B (bit 5), C (bit 6), D (bit 7). After an interface byte is taken, the search for the next one starts at the following bit.
- R4: Each D-type interface byte sets `proto_mask` bit number (byte & 0xF). Its bits 7:4 become the new presence mask, and the search restarts at bit 4.
- R5: A C-type interface byte is latched into `wi_value` only when the low nibble of the most recent D-type byte is 2. Any other C-type byte leaves `wi_value` unchanged. Only the format byte seen so far counts as a low nibble of 0.
- R6: Once no interface bytes remain, exactly the number of historical bytes given by the format byte is taken.
- R7: After the historical bytes (or the last interface byte when that count is 0), the sequence ends at once if `proto_mask` is 0x0001. Otherwise exactly one more byte, the check byte, is taken before the end.
- R8: `done` rises in the cycle after the clock edge that takes the final byte and stays high until reset. Bytes that arrive while `done` is high are not stored and change nothing.
- R9: `wait_etu` is 9600 until `done`. From the edge that takes the final byte it holds 960 × D × `wi_value`. D comes from `di_code` through the table 0,1,2,4,8,16,32,64,12,20,2,4,8,16,32,64 for codes 0..15.
- R10: Accepted bytes are written in order at `next_slot`, which then advances by one per byte and saturates at 63. Further bytes overwrite entry 63. `rd_data` shows entry `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts parsing |
| byte_valid | input | 1 | One-cycle strobe marking a received byte |
| byte_data | input | 8 | Received byte |
| di_code | input | 4 | Current rate adjustment code used for D |
| rd_addr | input | 6 | Buffer read address |
| rd_data | output | 8 | Buffer entry at rd_addr |
| next_slot | output | 6 | Buffer write position, saturating at 63 |
| done | output | 1 | Sequence complete, sticky |
| proto_mask | output | 16 | Announced protocol numbers |
| wi_value | output | 8 | Work waiting integer |
| wait_etu | output | 24 | Work waiting time in ETUs |

## Verification
Every registered result (`next_slot`, `proto_mask`, `wi_value`, `done`, `wait_etu`) is due one clock edge after the strobe that carries the byte. `rd_data` follows `rd_addr` in the same cycle. The bench drives each strobe on a falling edge and compares every output at the next falling edge against a reference model it advances in step with the byte. The buffer is read back only after the sequence is over, when no write is pending.

// File: rtl/atrp_pkg.sv
// Shared types and helpers for the answer-to-reset parser.
// Assumes direct convention bytes; no check-byte verification.
package atrp_pkg;

    typedef enum logic [3:0] {
        PH_INIT,   // waiting for initial character
        PH_FMT,    // waiting for format byte
        PH_IA,     // interface byte, A slot
        PH_IB,     // interface byte, B slot
        PH_IC,     // interface byte, C slot
        PH_ID,     // interface byte, D slot
        PH_HIST,   // historical bytes
        PH_CHK,    // check byte
        PH_END     // sequence complete
    } phase_t;

    // Rate adjustment code to D multiplier.
    function automatic logic [6:0] d_of_code(input logic [3:0] code);
        logic [6:0] d;
        case (code)
            4'd0:  d = 7'd0;
            4'd8:  d = 7'd12;
            4'd9:  d = 7'd20;
            default: d = (code < 4'd8) ? 7'(1 << (code - 4'd1)) : 7'(1 << (code - 4'd9));
        endcase
        return d;
    endfunction

endpackage

// File: rtl/atr_field_sel.sv
// Chooses the phase that follows an interface-byte decision point.
// Scans the presence nibble from position first_pos upward (A,B,C,D);
// when nothing is left, goes to historical bytes, the check byte or end.
// Purely combinational.
module atr_field_sel
    import atrp_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic [SLOTS-1:0] present,
    input  logic [2:0]       first_pos,
    input  logic             hist_pending,
    input  logic             only_t0,
    output phase_t           next_phase
);
    localparam int PW = $clog2(SLOTS);

    logic             hit;
    logic [PW-1:0]    hit_pos;

    // Lowest present slot at or above first_pos wins.
    always_comb begin
        hit     = 1'b0;
        hit_pos = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (present[i] && (i >= int'(first_pos))) begin
                hit     = 1'b1;
                hit_pos = PW'(i);
            end
        end
    end

    // Map the choice to a phase.
    always_comb begin
        if (hit)
            next_phase = phase_t'(int'(PH_IA) + int'(hit_pos));
        else if (hist_pending)
            next_phase = PH_HIST;
        else if (only_t0)
            next_phase = PH_END;
        else
            next_phase = PH_CHK;
    end
endmodule

// File: rtl/atr_byte_store.sv
// Byte buffer with a saturating write index and a combinational read port.
// Assumes one write per cycle at most; the index never wraps.
module atr_byte_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] wr_idx
);
    logic [DW-1:0] mem [DEPTH];

    // Store the byte and advance the index up to the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
            if (wr_idx != AW'(DEPTH - 1)) wr_idx <= wr_idx + 1'b1;
        end
    end

    // Read port.
    assign rd_data = mem[rd_addr];

    AST_IDX_HOLD_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == AW'(DEPTH - 1)) |=> (wr_idx == AW'(DEPTH - 1))); // R10
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != AW'(DEPTH - 1)) |=> (wr_idx == $past(wr_idx) + 1'b1)); // R10
endmodule

// File: rtl/atr_wait_calc.sv
// Holds the work waiting time: the initial value until loaded, then
// SCALE x D x WI taken at the load strobe. Assumes load pulses once.
module atr_wait_calc
    import atrp_pkg::*;
#(
    parameter int WT_W      = 24,
    parameter int WI_W      = 8,
    parameter int SCALE     = 960,
    parameter int INIT_WAIT = 9600
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [3:0]      di_code,
    input  logic [WI_W-1:0] wi,
    output logic [WT_W-1:0] wait_etu
);
    logic [31:0] product;

    // Multiplier from the D table, SCALE and WI.
    always_comb product = 32'(SCALE) * 32'(d_of_code(di_code)) * 32'(wi);

    // Register the result at the end of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)    wait_etu <= WT_W'(INIT_WAIT);
        else if (load) wait_etu <= WT_W'(product);
    end
endmodule

// File: rtl/atr_stream_parser.sv
// Passive answer-to-reset parser. Walks initial character, format byte,
// interface bytes, historical bytes and optional check byte; records the
// protocol mask and WI, computes the waiting time and buffers the bytes.
// Assumes byte_valid is a single-cycle strobe per received byte.
module atr_stream_parser
    import atrp_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int WT_W      = 24,
    parameter int WI_RESET  = 10,
    parameter int INIT_WAIT = 9600,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_valid,
    input  logic [7:0]      byte_data,
    input  logic [3:0]      di_code,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data,
    output logic [AW-1:0]   next_slot,
    output logic            done,
    output logic [15:0]     proto_mask,
    output logic [7:0]      wi_value,
    output logic [WT_W-1:0] wait_etu
);
    phase_t     phase, phase_nx, sel_phase;
    logic [3:0] hist_left, hist_nx;
    logic [7:0] last_td, last_td_nx;
    logic [15:0] mask_nx;
    logic [7:0] wi_nx;
    logic       store_en;
    logic [3:0] sel_present;
    logic [2:0] sel_first;
    logic       sel_hist;

    // Selector inputs depend on which byte is being taken.
    always_comb begin
        sel_present = last_td[7:4];
        sel_first   = 3'd0;
        sel_hist    = hist_left != 4'd0;
        unique case (phase)
            PH_FMT: begin
                sel_present = byte_data[7:4];
                sel_hist    = byte_data[3:0] != 4'd0;
            end
            PH_IA: sel_first = 3'd1;
            PH_IB: sel_first = 3'd2;
            PH_IC: sel_first = 3'd3;
            PH_ID: sel_present = byte_data[7:4];
            default: ;
        endcase
    end

    atr_field_sel #(.SLOTS(4)) u_sel (
        .present      (sel_present),
        .first_pos    (sel_first),
        .hist_pending (sel_hist),
        .only_t0      (mask_nx == 16'h0001),
        .next_phase   (sel_phase)
    );

    // Next-state and field updates for one received byte.
    always_comb begin
        phase_nx   = phase;
        hist_nx    = hist_left;
        last_td_nx = last_td;
        mask_nx    = proto_mask;
        wi_nx      = wi_value;
        store_en   = 1'b0;
        if (byte_valid) begin
            unique case (phase)
                PH_INIT: if (byte_data != 8'h00) begin
                    store_en = 1'b1;
                    phase_nx = PH_FMT;
                end
                PH_FMT: begin
                    store_en   = 1'b1;
                    hist_nx    = byte_data[3:0];
                    last_td_nx = {byte_data[7:4], 4'h0};
                    phase_nx   = sel_phase;
                end
                PH_IA, PH_IB: begin
                    store_en = 1'b1;
                    phase_nx = sel_phase;
                end
                PH_IC: begin
                    store_en = 1'b1;
                    if (last_td[3:0] == 4'd2) wi_nx = byte_data;
                    phase_nx = sel_phase;
                end
                PH_ID: begin
                    store_en   = 1'b1;
                    last_td_nx = byte_data;
                    mask_nx    = proto_mask | (16'h0001 << byte_data[3:0]);
                    phase_nx   = sel_phase;
                end
                PH_HIST: begin
                    store_en = 1'b1;
                    hist_nx  = hist_left - 4'd1;
                    if (hist_left == 4'd1)
                        phase_nx = (proto_mask == 16'h0001) ? PH_END : PH_CHK;
                end
                PH_CHK: begin
                    store_en = 1'b1;
                    phase_nx = PH_END;
                end
                default: ;
            endcase
        end
    end

    // Parser state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_INIT;
            hist_left  <= '0;
            last_td    <= '0;
            proto_mask <= 16'h0001;
            wi_value   <= 8'(WI_RESET);
        end else begin
            phase      <= phase_nx;
            hist_left  <= hist_nx;
            last_td    <= last_td_nx;
            proto_mask <= mask_nx;
            wi_value   <= wi_nx;
        end
    end

    assign done = (phase == PH_END);

    atr_byte_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_data (byte_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_idx  (next_slot)
    );

    atr_wait_calc #(.WT_W(WT_W), .WI_W(8), .SCALE(960), .INIT_WAIT(INIT_WAIT)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((phase_nx == PH_END) && (phase != PH_END)),
        .di_code  (di_code),
        .wi       (wi_nx),
        .wait_etu (wait_etu)
    );

    AST_INIT_ZERO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INIT && byte_valid && byte_data == 8'h00) |=> $stable(next_slot)); // R2
    AST_T0_ALWAYS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        proto_mask[0]); // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R8
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && byte_valid) |=> ($stable(next_slot) && $stable(proto_mask) && $stable(wi_value))); // R8
    AST_WAIT_BEFORE_END: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (wait_etu == WT_W'(INIT_WAIT))); // R9
    AST_WI_ONLY_IN_C: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IC) |=> $stable(wi_value)); // R5
endmodule

// File: tb/atr_stream_parser_test.sv
module atr_stream_parser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [3:0]  di_code = 4'd1;
    logic [5:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [5:0]  next_slot;
    logic        done;
    logic [15:0] proto_mask;
    logic [7:0]  wi_value;
    logic [23:0] wait_etu;

    int errors = 0;
    int checks = 0;

    // Reference model state
    int        m_ph;      // 0 init,1 fmt,2..5 A..D,6 hist,7 chk,8 end
    int        m_hist;
    logic [7:0] m_last;
    logic [15:0] m_mask;
    logic [7:0] m_wi;
    int        m_idx;
    logic [7:0] m_buf [64];
    logic [23:0] m_wait;

    always #2 clk = ~clk;

    atr_stream_parser uut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .di_code(di_code), .rd_addr(rd_addr), .rd_data(rd_data), .next_slot(next_slot),
        .done(done), .proto_mask(proto_mask), .wi_value(wi_value), .wait_etu(wait_etu)
    );

    function automatic int dval(input logic [3:0] c);
        int t [16] = '{0,1,2,4,8,16,32,64,12,20,2,4,8,16,32,64};
        return t[c];
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_pick(input int from);
        for (int p = from; p < 4; p++) if (m_last[4+p]) return 2 + p;
        if (m_hist != 0) return 6;
        return (m_mask == 16'h0001) ? 8 : 7;
    endfunction

    task automatic m_reset();
        m_ph = 0; m_hist = 0; m_last = 0; m_mask = 16'h0001; m_wi = 8'd10;
        m_idx = 0; m_wait = 24'd9600;
        for (int i = 0; i < 64; i++) m_buf[i] = 8'h00;
    endtask

    task automatic m_byte(input logic [7:0] b);
        int prev = m_ph;
        if (m_ph == 8) return;
        if (m_ph == 0 && b == 8'h00) return;
        m_buf[m_idx] = b;
        if (m_idx < 63) m_idx++;
        case (m_ph)
            0: m_ph = 1;
            1: begin m_hist = b[3:0]; m_last = {b[7:4], 4'h0}; m_ph = m_pick(0); end
            2: m_ph = m_pick(1);
            3: m_ph = m_pick(2);
            4: begin if (m_last[3:0] == 4'd2) m_wi = b; m_ph = m_pick(3); end
            5: begin m_last = b; m_mask[b[3:0]] = 1'b1; m_ph = m_pick(0); end
            6: begin m_hist--; if (m_hist == 0) m_ph = (m_mask == 16'h0001) ? 8 : 7; end
            7: m_ph = 8;
            default: ;
        endcase
        if (m_ph == 8 && prev != 8) m_wait = 24'(960 * dval(di_code) * int'(m_wi));
    endtask

    task automatic compare_outs(input string tag);
        chk("R8", {tag, " done"}, done, m_ph == 8);
        chk("R10", {tag, " next_slot"}, next_slot, m_idx);
        chk("R4", {tag, " proto_mask"}, proto_mask, m_mask);
        chk("R5", {tag, " wi_value"}, wi_value, m_wi);
        chk("R9", {tag, " wait_etu"}, wait_etu, m_wait);
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        @(negedge clk);
        byte_data = b; byte_valid = 1'b1;
        m_byte(b);
        @(negedge clk);
        byte_valid = 1'b0;
        compare_outs(tag);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_reset();
    endtask

    task automatic check_buffer(input string tag);
        for (int i = 0; i < 64; i++) begin
            rd_addr = 6'(i);
            #1;
            chk("R10", {tag, " buffer"}, rd_data, m_buf[i]);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_reset();
        do_reset();
        @(negedge clk);
        // R1: reset state
        compare_outs("R1 reset");
        check_buffer("R1 reset");

        // R2: zeros dropped before initial char; R7: T=0 only, no hist -> immediate end
        di_code = 4'd1;
        send(8'h00, "R2 zero");
        send(8'h00, "R2 zero");
        send(8'h3B, "R2 ts");
        send(8'h00, "R7 fmt");
        chk("R7", "immediate end", done, 1);
        send(8'h55, "R8 ignored");
        check_buffer("R8 after");

        // R3/R5/R6/R7: TD with protocol 2, TC2 latches WI, hist, check byte
        do_reset(); di_code = 4'd9;
        send(8'h3B, "R3"); send(8'hD2, "R3 fmt");  // A,C,D present, 2 hist
        send(8'h11, "R3 ta"); send(8'h07, "R5 tc1");
        send(8'h82, "R4 td1"); send(8'h42, "R4 td2");
        send(8'h2A, "R5 tc3"); send(8'h61, "R6 h1"); send(8'h62, "R6 h2");
        chk("R7", "awaits check byte", done, 0);
        send(8'hEE, "R7 tck");
        chk("R9", "wait value", wait_etu, 960 * 20 * 42);
        check_buffer("R10 directed");

        // R10: saturation with a long D chain
        do_reset(); di_code = 4'd3;
        send(8'h3B, "R10"); send(8'h80, "R10 fmt");
        for (int k = 0; k < 70; k++) send(8'h81, "R10 chain");
        send(8'h00, "R10 last td"); send(8'hA5, "R10 tck");
        chk("R10", "saturated", next_slot, 63);
        check_buffer("R10 sat");

        // Random sequences
        for (int n = 0; n < 150; n++) begin
            do_reset();
            di_code = 4'($urandom_range(0, 15));
            for (int k = 0; k < 120 && m_ph != 8; k++) begin
                logic [7:0] b = 8'($urandom);
                if ($urandom_range(0, 7) == 0) b = 8'h00;
                send(b, "rand");
            end
            send(8'($urandom), "R8 rand post");
            check_buffer("rand");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule